// File: doc/BRIEF.md
# DDR Refresh and Self-Refresh Sequencer

This block keeps a DDR SDRAM refreshed on behalf of a command scheduler. A free-running interval counter, programmed with a divisor in clock cycles, produces one refresh credit per interval. Credits pile up in an owed counter that can hold a bounded number of postponed refreshes. While anything is owed, the block raises a bus request toward the scheduler. When the owed counter is full, it also marks the request as urgent.

Once the scheduler grants the bus, the sequencer closes every bank with a precharge-all command (address bit 10 high). It waits out the precharge time and any remaining activate-to-activate spacing since the scheduler's last activate. It then issues the auto-refresh command. After the refresh cycle time has elapsed, it hands the bus back with a one-cycle done pulse.

If the self-refresh hold input is high when the grant arrives, the refresh command is instead issued with CKE low, which enters self-refresh. CKE stays low until the hold input drops. After CKE returns high, the bus is handed back once the short non-read exit delay has passed. A separate read-permit output stays low until the much longer read exit delay has also passed.

Top module: `refresh_sequencer`

## Requirements
- R1: The interval counter produces one tick every `intervalDiv` cycles after reset (divisor of 2 or more), and each tick raises `owedCount` by one.
- R2: `owedCount` never exceeds DEBT_MAX; a tick that arrives while it is full is dropped. `reqUrgent` is high exactly when `owedCount` equals DEBT_MAX.
- R3: While idle, `busReq` is high whenever `owedCount` is nonzero or `srHold` is high. Once the request is granted, `busReq` stays high until the cycle of `seqDone`, where it is low.
- R4: The cycle after an idle cycle with both `busReq` and `busGrant` high, the block issues a precharge-all: `cmdOp` = 2'b01 and `cmdA10` = 1. In every other cycle `cmdA10` is 0, and `cmdOp` = 2'b00 whenever no command is being issued.
- R5: The refresh command (`cmdOp` = 2'b10) comes at the first cycle that is at least T_RP cycles after the precharge-all and at least T_RRD cycles after the last cycle with `actSeen` high.
- R6: Each refresh issued with CKE high lowers `owedCount` by one.
- R7: After an auto refresh, `seqDone` is a single-cycle pulse exactly T_RFC-1 cycles after the refresh command, so the scheduler may issue again T_RFC cycles after the refresh.
- R8: If `srHold` is high in the accepted grant cycle, the refresh command is issued with `cke` low. `owedCount` is cleared at that point. `cke` stays low until the first cycle after `srHold` is seen low in a cycle following the refresh, so it is low for at least two cycles.
- R9: No interval tick adds to `owedCount` in a cycle where `cke` is low.
- R10: After a self-refresh exit, `seqDone` pulses exactly T_XSNR-1 cycles after the first cycle with `cke` high again.
- R11: `readOk` is low from the self-refresh entry cycle until T_XSRD cycles after `cke` returns high, and high otherwise.
- R12: During reset, `busReq`, `seqDone` and `owedCount` are 0, `cmdOp` is 2'b00, and both `cke` and `readOk` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intervalDiv | input | DIV_W | Refresh interval in clock cycles |
| actSeen | input | 1 | Scheduler issued a bank activate this cycle |
| srHold | input | 1 | Request to enter and stay in self-refresh |
| busGrant | input | 1 | Scheduler hands the command bus to the sequencer |
| busReq | output | 1 | Sequencer wants the command bus |
| reqUrgent | output | 1 | Owed refreshes are at their limit |
| seqDone | output | 1 | Bus released this cycle |
| cmdOp | output | 2 | Command: 00 none, 01 precharge-all, 10 refresh |
| cmdA10 | output | 1 | Address bit 10 for the issued command |
| cke | output | 1 | Clock enable to the DRAM |
| owedCount | output | $clog2(DEBT_MAX+1) | Number of postponed refreshes |
| readOk | output | 1 | Read commands are permitted |

## Verification
The bench builds the block with DEBT_MAX=4 and DIV_W=8 and drives an interval divisor of 30. With those values the owed counter fills, and starts dropping ticks, within about 120 cycles. The timing parameters keep their default values: T_RP=3, T_RFC=10, T_RRD=9, T_XSNR=10 and T_XSRD=200. This exercises the true gap between the 10-cycle non-read exit and the 200-cycle read exit. Activate pulses placed just before a grant make the activate spacing, not the precharge time, set the refresh cycle. A self-refresh whose hold drops at once covers the minimum CKE low time.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PREA = 2'b01,
    OP_REF  = 2'b10
  } cmdOp_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREA,
    ST_RPWAIT,
    ST_REF,
    ST_SRENTER,
    ST_SELF,
    ST_SREXIT,
    ST_TWAIT,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRp;
    logic loadRfc;
    logic loadXsnr;
    logic loadXsrd;
    logic decDebt;
    logic clrDebt;
    logic ckeLow;
  } seqStrobe_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DEBT_MAX = 8,
  parameter int DEBT_W   = $clog2(DEBT_MAX + 1),
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int T_RRD    = 9,
  parameter int T_XSNR   = 10,
  parameter int T_XSRD   = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  intervalDiv,
  input  logic              actSeen,
  input  seqStrobe_t        strb,
  output logic              timerZero,
  output logic              refGateOpen,
  output logic              rrdClear,
  output logic              readZero,
  output logic [DEBT_W-1:0] owedCount,
  output logic              owedFull
);

  localparam int TMAX_A = (T_RFC > T_XSNR) ? T_RFC : T_XSNR;
  localparam int TMAX   = (TMAX_A > T_RP) ? TMAX_A : T_RP;
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int RRD_W  = $clog2(T_RRD + 1);
  localparam int XSRD_W = $clog2(T_XSRD + 1);

  // interval counter
  logic [DIV_W-1:0] intCnt;
  logic             intTick;

  assign intTick = (intCnt == intervalDiv - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        intCnt <= '0;
    else if (intTick) intCnt <= '0;
    else              intCnt <= intCnt + DIV_W'(1);
  end

  // owed refresh counter
  logic [DEBT_W-1:0] debtQ;
  logic              debtInc;

  assign owedFull = (debtQ == DEBT_W'(DEBT_MAX));
  assign debtInc  = intTick && !strb.ckeLow && !owedFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debtQ <= '0;
    end else if (strb.clrDebt) begin
      debtQ <= '0;
    end else begin
      case ({debtInc, strb.decDebt})
        2'b10:   debtQ <= debtQ + DEBT_W'(1);
        2'b01:   debtQ <= debtQ - DEBT_W'(1);
        default: debtQ <= debtQ;
      endcase
    end
  end

  assign owedCount = debtQ;

  // shared wait timer
  logic [TMR_W-1:0] timerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerQ <= '0;
    else if (strb.loadRp)     timerQ <= TMR_W'(T_RP - 2);
    else if (strb.loadRfc)    timerQ <= TMR_W'(T_RFC - 3);
    else if (strb.loadXsnr)   timerQ <= TMR_W'(T_XSNR - 3);
    else if (timerQ != '0)    timerQ <= timerQ - TMR_W'(1);
  end

  assign timerZero = (timerQ == '0);

  // activate spacing tracker
  generate
    if (T_RRD > 1) begin : g_rrd
      logic [RRD_W-1:0] rrdLeft;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               rrdLeft <= '0;
        else if (actSeen)        rrdLeft <= RRD_W'(T_RRD - 1);
        else if (rrdLeft != '0)  rrdLeft <= rrdLeft - RRD_W'(1);
      end
      assign refGateOpen = (rrdLeft <= RRD_W'(1)) && !actSeen;
      assign rrdClear    = (rrdLeft == '0);
    end else begin : g_norrd
      assign refGateOpen = 1'b1;
      assign rrdClear    = 1'b1;
    end
  endgenerate

  // read exit delay counter
  logic [XSRD_W-1:0] readCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              readCnt <= '0;
    else if (strb.loadXsrd) readCnt <= XSRD_W'(T_XSRD - 1);
    else if (readCnt != '0) readCnt <= readCnt - XSRD_W'(1);
  end

  assign readZero = (readCnt == '0);

  // R2
  debt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    owedCount <= DEBT_W'(DEBT_MAX));

  // R9
  debt_sr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ckeLow |=> (owedCount <= $past(owedCount)));

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srHold,
  input  logic       busGrant,
  input  logic       timerZero,
  input  logic       refGateOpen,
  input  logic       rrdClear,
  input  logic       readZero,
  input  logic       owedNonZero,
  output seqStrobe_t strb,
  output logic       busReq,
  output logic       seqDone,
  output cmdOp_e     cmdOp,
  output logic       cmdA10,
  output logic       cke,
  output logic       readOk
);

  seqState_e st, stNxt;
  logic      srModeQ;
  logic      srBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      srModeQ <= 1'b0;
    end else begin
      st <= stNxt;
      if (st == ST_IDLE && busGrant && busReq) srModeQ <= srHold;
    end
  end

  always_comb begin
    stNxt = st;
    strb  = '0;
    case (st)
      ST_IDLE:    if (busGrant && busReq) stNxt = ST_PREA;
      ST_PREA: begin
        strb.loadRp = 1'b1;
        stNxt       = ST_RPWAIT;
      end
      ST_RPWAIT:  if (timerZero && refGateOpen) stNxt = srModeQ ? ST_SRENTER : ST_REF;
      ST_REF: begin
        strb.loadRfc = 1'b1;
        strb.decDebt = 1'b1;
        stNxt        = ST_TWAIT;
      end
      ST_SRENTER: begin
        strb.clrDebt = 1'b1;
        strb.ckeLow  = 1'b1;
        stNxt        = ST_SELF;
      end
      ST_SELF: begin
        strb.ckeLow = 1'b1;
        if (!srHold) stNxt = ST_SREXIT;
      end
      ST_SREXIT: begin
        strb.loadXsnr = 1'b1;
        strb.loadXsrd = 1'b1;
        stNxt         = ST_TWAIT;
      end
      ST_TWAIT:   if (timerZero) stNxt = ST_DONE;
      ST_DONE:    stNxt = ST_IDLE;
      default:    stNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st)
      ST_PREA:             cmdOp = OP_PREA;
      ST_REF, ST_SRENTER:  cmdOp = OP_REF;
      default:             cmdOp = OP_NONE;
    endcase
  end

  assign srBusy  = (st == ST_SRENTER) || (st == ST_SELF) || (st == ST_SREXIT);
  assign busReq  = (st == ST_IDLE) ? (owedNonZero || srHold) : (st != ST_DONE);
  assign seqDone = (st == ST_DONE);
  assign cmdA10  = (st == ST_PREA);
  assign cke     = !((st == ST_SRENTER) || (st == ST_SELF));
  assign readOk  = readZero && !srBusy;

  // R8
  cke_low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |=> !cke);

  // R8
  cke_high_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |=> cke);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R5
  ref_rrd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == OP_REF) |-> rrdClear);

  // R11
  read_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |=> !readOk);

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import rfsh_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DEBT_MAX = 8,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int T_RRD    = 9,
  parameter int T_XSNR   = 10,
  parameter int T_XSRD   = 200,
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  intervalDiv,
  input  logic              actSeen,
  input  logic              srHold,
  input  logic              busGrant,
  output logic              busReq,
  output logic              reqUrgent,
  output logic              seqDone,
  output logic [1:0]        cmdOp,
  output logic              cmdA10,
  output logic              cke,
  output logic [DEBT_W-1:0] owedCount,
  output logic              readOk
);

  seqStrobe_t strb;
  cmdOp_e     cmdOpE;
  logic       timerZero, refGateOpen, rrdClear, readZero, owedFull;

  rfsh_datapath #(
    .DIV_W(DIV_W), .DEBT_MAX(DEBT_MAX), .DEBT_W(DEBT_W), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_RRD(T_RRD), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .intervalDiv(intervalDiv), .actSeen(actSeen),
    .strb(strb), .timerZero(timerZero), .refGateOpen(refGateOpen),
    .rrdClear(rrdClear), .readZero(readZero), .owedCount(owedCount),
    .owedFull(owedFull)
  );

  rfsh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srHold(srHold), .busGrant(busGrant),
    .timerZero(timerZero), .refGateOpen(refGateOpen), .rrdClear(rrdClear),
    .readZero(readZero), .owedNonZero(owedCount != '0), .strb(strb),
    .busReq(busReq), .seqDone(seqDone), .cmdOp(cmdOpE), .cmdA10(cmdA10),
    .cke(cke), .readOk(readOk)
  );

  assign cmdOp     = cmdOpE;
  assign reqUrgent = owedFull;

endmodule

// File: tb/sim_refresh_sequencer.sv
`timescale 1ns/100ps
module sim_refresh_sequencer;

  localparam int DIV_W = 8, DMAX = 4, TRP = 3, TRFC = 10, TRRD = 9, TXSNR = 10, TXSRD = 200;
  localparam int BIG = 1 << 30;

  logic clk = 0, rstN = 0, actSeen = 0, srHold = 0, busGrant = 0;
  logic [DIV_W-1:0] intervalDiv = 8'd30;
  logic busReq, reqUrgent, seqDone, cmdA10, cke, readOk;
  logic [1:0] cmdOp;
  logic [2:0] owedCount;

  int total = 0, bad = 0;
  int grantEn = 0, running = 0, finished = 0;

  // reference model state
  int cyc = 0, mPos = 0, mDebt = 0, mBusy = 0, mSr = 0;
  int preAt = -1000, refAt = -1000, doneAt = -1000, lastAct = -1000;
  int enterAt = -1000, exitAt = -1000, rdUntil = -1000;

  always #2 clk = ~clk;

  refresh_sequencer #(.DIV_W(DIV_W), .DEBT_MAX(DMAX), .T_RP(TRP), .T_RFC(TRFC),
    .T_RRD(TRRD), .T_XSNR(TXSNR), .T_XSRD(TXSRD)) u0 (
    .clk(clk), .rstN(rstN), .intervalDiv(intervalDiv), .actSeen(actSeen),
    .srHold(srHold), .busGrant(busGrant), .busReq(busReq), .reqUrgent(reqUrgent),
    .seqDone(seqDone), .cmdOp(cmdOp), .cmdA10(cmdA10), .cke(cke),
    .owedCount(owedCount), .readOk(readOk));

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", what, cyc, act, exp);
    end
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      actSeen  = 0;
      busGrant = (grantEn != 0) && busReq;
    end
  endtask

  // per-cycle compare against the behavioural model
  always @(negedge clk) begin
    if (running != 0) begin
      int tick, ckeLowNow, debtNow, inc, dec, expOp;
      expOp = (cyc == preAt) ? 1 : ((cyc == refAt) ? 2 : 0);
      ckeLowNow = (cyc >= enterAt && cyc < exitAt) ? 1 : 0;
      chk("R3 busReq", busReq, mBusy ? (cyc != doneAt) : (mDebt != 0 || srHold));
      chk("R4/R5 cmdOp", cmdOp, expOp);
      chk("R4 cmdA10", cmdA10, cyc == preAt);
      chk("R8 cke", cke, !ckeLowNow);
      chk("R7/R10 seqDone", seqDone, mBusy && cyc == doneAt);
      chk("R1/R6/R9 owedCount", owedCount, mDebt);
      chk("R2 reqUrgent", reqUrgent, mDebt == DMAX);
      chk("R11 readOk", readOk, !(cyc >= enterAt && cyc < rdUntil));

      debtNow = mDebt;
      tick = (mPos == int'(intervalDiv) - 1) ? 1 : 0;
      mPos = tick ? 0 : mPos + 1;
      if (mBusy && mSr && cyc == refAt) mDebt = 0;
      else begin
        inc = (tick && !ckeLowNow && mDebt != DMAX) ? 1 : 0;
        dec = (mBusy && !mSr && cyc == refAt) ? 1 : 0;
        mDebt = mDebt + inc - dec;
      end
      if (actSeen) lastAct = cyc;
      if (mBusy) begin
        if (cyc == doneAt) mBusy = 0;
        else if (mSr && cyc > refAt && exitAt == BIG && !srHold) begin
          exitAt  = cyc + 1;
          doneAt  = cyc + TXSNR;
          rdUntil = cyc + 1 + TXSRD;
        end
      end else if (busGrant && (debtNow != 0 || srHold)) begin
        mBusy = 1;
        mSr   = srHold;
        preAt = cyc + 1;
        refAt = maxi(cyc + 1 + TRP, lastAct + TRRD);
        if (!srHold) doneAt = refAt + TRFC - 1;
        else begin
          doneAt = BIG; enterAt = refAt; exitAt = BIG; rdUntil = BIG;
        end
      end
      cyc++;
    end
  end

  initial begin
    #(4 * 200000);
    if (finished == 0) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    // R12 reset values
    chk("R12 busReq", busReq, 0);
    chk("R12 seqDone", seqDone, 0);
    chk("R12 cmdOp", cmdOp, 0);
    chk("R12 owedCount", owedCount, 0);
    chk("R12 cke", cke, 1);
    chk("R12 readOk", readOk, 1);
    rstN = 1; running = 1;
    // owed fills and saturates (R1, R2)
    step(150);
    // activate just before grant: spacing sets refresh cycle (R5)
    actSeen = 1; step(1);
    grantEn = 1; step(1);
    step(200);
    // hold off, let debt build, then activates before granting
    grantEn = 0; step(40);
    actSeen = 1; step(3);
    actSeen = 1; step(1);
    grantEn = 1; step(120);
    // long self-refresh (R8, R9, R10, R11)
    srHold = 1; step(100);
    srHold = 0; step(260);
    // minimum self-refresh: drop hold as soon as cke falls
    srHold = 1;
    for (int i = 0; i < 80 && cke; i++) step(1);
    srHold = 0; step(260);
    running = 0; finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule